// File: doc/BRIEF.md
# Serial Clock Register File

This block is the byte-level register side of a serial real-time clock. It keeps a running time of day and calendar in packed BCD. A bus target front end, which handles the bit-level signalling and address matching, reaches that time through an 8-bit register pointer that advances by one after every byte.

The front end passes on three events:

- a strobe for the start of a write transaction;
- a written byte, with its data;
- a read request, answered with one data byte on the following cycle.

A separate tick enable, pulsed at 100 Hz, advances the clock.

No byte stream here has back-pressure. Every written byte and every read request is accepted in the cycle it is presented, so there is no ready signal. `rd_valid` is the valid half of the read stream, and the front end must take the byte in that cycle. The front end keeps the three events in separate cycles. If a start or a written byte arrives in the same cycle as a read, the start or the byte updates the pointer.

Top module: `srtc_regs`

## Requirements
- R1: After reset the time reads 00:00:00.00, with day of week 06, date 01, month 01 and year 00, and the pointer is unset.
- R2: A read request sampled at a clock edge produces `rd_valid` high, with `rd_data` and `bad_addr`, for exactly the cycle after that edge. `rd_valid` is low in every other cycle.
- R3: A read while the pointer is unset first sets the pointer to 0. Every read returns the register at the pointer and then adds one to the pointer.
- R4: The start strobe makes the pointer unset. The first byte written while the pointer is unset is loaded as the pointer. Each later byte only adds one to the pointer, and its data is discarded.
- R5: The registers are packed BCD (tens digit in bits 7:4, units digit in bits 3:0), at these addresses:

  | Address | Content |
  |---|---|
  | 0 | hundredths of a second |
  | 1 | seconds |
  | 2 | minutes |
  | 3 | hours |
  | 4 | day of week |
  | 5 | date |
  | 6 | month |
  | 7 | year |
- R6: Each tick advances hundredths from 00 to 99. The carry then moves through seconds (00-59), minutes (00-59) and hours (00-23), with these tops set by parameters.
- R7: At the end of each day, two things advance. Day of week counts 0 to 6, with 0 meaning Sunday. The date wraps to 01 after the month's last day, and that wrap advances the month (01-12), which in turn advances the year (00-99, wrapping).
- R8: A month has 31 or 30 days. February has 29 days when the two-digit year is a multiple of 4, and 28 days otherwise.
- R9: A read at address 1 latches a snapshot of addresses 1 to 7. Reads at addresses 2 to 7 return that snapshot; before the first such read, the snapshot holds the reset time. Address 0 always returns the live hundredths.
- R10: Addresses 8 to 19 read as 0x00 with `bad_addr` low. Addresses above 19 read as 0x00 with `bad_addr` high for that single response cycle.
- R11: The pointer is 8 bits wide and wraps from 255 to 0, and the address after the wrap reads as a valid address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | 100 Hz advance enable, one cycle wide |
| xfer_start | input | 1 | Start of a write transaction |
| wr_valid | input | 1 | Written byte present |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Read one byte |
| rd_valid | output | 1 | Read byte present, one cycle after `rd_req` |
| rd_data | output | 8 | Read byte |
| bad_addr | output | 1 | Read hit an address above 19 |

## Verification
Each read response is due in the cycle after the edge that samples `rd_req`, and `bad_addr` is due in that same cycle. A tick is visible in the registers from the edge that samples it, and a pointer update shows up on the next read.

The bench stamps every expected byte with the cycle count at which it is due. It drives inputs and samples outputs on the falling edge, and it flags both a response that arrives without a pending expectation and an expectation whose due cycle passes with no response.

Calendar rollovers, including the leap-year February, are reached through a second instance with shortened time-of-day tops. Both instances are checked against one reference model.

// File: rtl/srtc_pkg.sv
package srtc_pkg;

  // Field order sets the read address: hund is byte 0, year is byte 7.
  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] minute;
    logic [7:0] sec;
    logic [7:0] hund;
  } srtc_time_t;

  function automatic logic [7:0] to_bcd(input int v);
    to_bcd = {4'(v / 10), 4'(v % 10)};
  endfunction

  localparam srtc_time_t SRTC_RST = '{
    year: 8'h00, mon: 8'h01, date: 8'h01, dow: 8'h06,
    hour: 8'h00, minute: 8'h00, sec: 8'h00, hund: 8'h00
  };

endpackage

// File: rtl/srtc_bcd_ctr.sv
module srtc_bcd_ctr
  import srtc_pkg::*;
#(
  parameter int LO  = 0,
  parameter int RST = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [7:0] top,
  output logic [7:0] val
);
  localparam logic [7:0] LO_B  = to_bcd(LO);
  localparam logic [7:0] RST_B = to_bcd(RST);

  logic [7:0] nxt;

  always_comb begin
    if (val == top)
      nxt = LO_B;
    else if (val[3:0] == 4'd9)
      nxt = {val[7:4] + 4'd1, 4'd0};
    else
      nxt = {val[7:4], val[3:0] + 4'd1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      val <= RST_B;
    else if (step)
      val <= nxt;
  end
endmodule

// File: rtl/srtc_timekeeper.sv
module srtc_timekeeper
  import srtc_pkg::*;
#(
  parameter int HUND_TOP = 99,
  parameter int SEC_TOP  = 59,
  parameter int MIN_TOP  = 59,
  parameter int HOUR_TOP = 23
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  output srtc_time_t now
);
  localparam int NTOD = 4;
  localparam int TOD_TOP [NTOD] = '{HUND_TOP, SEC_TOP, MIN_TOP, HOUR_TOP};

  logic [NTOD:0] cy;
  logic [7:0]    tod [NTOD];

  assign cy[0] = tick_en;

  // time-of-day chain: hundredths, seconds, minutes, hours
  for (genvar g = 0; g < NTOD; g++) begin : g_tod
    localparam logic [7:0] TB = to_bcd(TOD_TOP[g]);
    srtc_bcd_ctr #(.LO(0), .RST(0)) u_ctr (
      .clk  (clk),
      .rst_n(rst_n),
      .step (cy[g]),
      .top  (TB),
      .val  (tod[g])
    );
    assign cy[g+1] = cy[g] && (tod[g] == TB);
  end

  assign now.hund   = tod[0];
  assign now.sec    = tod[1];
  assign now.minute = tod[2];
  assign now.hour   = tod[3];

  logic       day_step, mon_step, yr_step, leap;
  logic [1:0] yr_mod4;
  logic [7:0] mlen;

  // year mod 4 from BCD digits: (2*tens + units) mod 4
  assign yr_mod4 = {now.year[4], 1'b0} + now.year[1:0];
  assign leap    = (yr_mod4 == 2'd0);

  always_comb begin
    case (now.mon)
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  assign day_step = cy[NTOD];
  assign mon_step = day_step && (now.date == mlen);
  assign yr_step  = mon_step && (now.mon == 8'h12);

  srtc_bcd_ctr #(.LO(0), .RST(6)) u_dow (
    .clk(clk), .rst_n(rst_n), .step(day_step), .top(8'h06), .val(now.dow));
  srtc_bcd_ctr #(.LO(1), .RST(1)) u_date (
    .clk(clk), .rst_n(rst_n), .step(day_step), .top(mlen), .val(now.date));
  srtc_bcd_ctr #(.LO(1), .RST(1)) u_mon (
    .clk(clk), .rst_n(rst_n), .step(mon_step), .top(8'h12), .val(now.mon));
  srtc_bcd_ctr #(.LO(0), .RST(0)) u_year (
    .clk(clk), .rst_n(rst_n), .step(yr_step), .top(8'h99), .val(now.year));
endmodule

// File: rtl/srtc_ptr.sv
module srtc_ptr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_addr,
  output logic              ptr_set
);
  logic [DATA_W-1:0] ptr;

  assign rd_addr = ptr_set ? ptr : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= '0;
      ptr_set <= 1'b0;
    end else if (xfer_start) begin
      // a byte in the start cycle is the first byte of the transaction
      ptr_set <= wr_valid;
      if (wr_valid) ptr <= wr_data;
    end else if (wr_valid) begin
      ptr     <= ptr_set ? ptr + 1'b1 : wr_data;
      ptr_set <= 1'b1;
    end else if (rd_req) begin
      ptr     <= rd_addr + 1'b1;
      ptr_set <= 1'b1;
    end
  end
endmodule

// File: rtl/srtc_rdport.sv
module srtc_rdport
  import srtc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAST_RSV = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] rd_addr,
  input  srtc_time_t        now,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_addr
);
  localparam int NUM_LIVE = $bits(srtc_time_t) / 8;
  localparam int IDX_W    = $clog2(NUM_LIVE);

  srtc_time_t snap;
  logic [7:0] snap_b [NUM_LIVE];
  logic [7:0] sel;

  for (genvar k = 0; k < NUM_LIVE; k++) begin : g_snap
    assign snap_b[k] = snap[8*k +: 8];
  end

  always_comb begin
    if (rd_addr == 0)
      sel = now.hund;
    else if (rd_addr == 1)
      sel = now.sec;
    else if (int'(rd_addr) < NUM_LIVE)
      sel = snap_b[rd_addr[IDX_W-1:0]];
    else
      sel = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bad_addr <= 1'b0;
      snap     <= SRTC_RST;
    end else begin
      rd_valid <= rd_req;
      bad_addr <= rd_req && (int'(rd_addr) > LAST_RSV);
      if (rd_req) begin
        rd_data <= DATA_W'(sel);
        if (rd_addr == 1) snap <= now;
      end
    end
  end
endmodule

// File: rtl/srtc_regs.sv
module srtc_regs
  import srtc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int LAST_RSV = 19,
  parameter int HUND_TOP = 99,
  parameter int SEC_TOP  = 59,
  parameter int MIN_TOP  = 59,
  parameter int HOUR_TOP = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              xfer_start,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              bad_addr
);
  srtc_time_t        now_t;
  logic [DATA_W-1:0] rd_addr;
  logic              ptr_set;

  srtc_timekeeper #(
    .HUND_TOP(HUND_TOP), .SEC_TOP(SEC_TOP),
    .MIN_TOP(MIN_TOP),   .HOUR_TOP(HOUR_TOP)
  ) u_time (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .now(now_t));

  srtc_ptr #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .ptr_set(ptr_set));

  srtc_rdport #(.DATA_W(DATA_W), .LAST_RSV(LAST_RSV)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .now(now_t),
    .rd_valid(rd_valid), .rd_data(rd_data), .bad_addr(bad_addr));
endmodule

// File: rtl/srtc_regs_chk.sv
module srtc_regs_chk
  import srtc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HUND_TOP = 99
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              xfer_start,
  input logic              wr_valid,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              bad_addr,
  input logic [DATA_W-1:0] rd_data,
  input logic              ptr_set,
  input logic [7:0]        hund,
  input logic [7:0]        sec,
  input logic [7:0]        mon,
  input logic [7:0]        date
);
  localparam logic [7:0] HTOP_B = to_bcd(HUND_TOP);

  p_rd_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_read_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !xfer_start && !wr_valid) |=> ptr_set);
  p_start_unsets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !wr_valid) |=> !ptr_set);
  p_hund_digits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hund[3:0] <= 4'd9) && (hund[7:4] <= 4'd9));
  p_sec_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick_en && hund == HTOP_B) |=> $stable(sec));
  p_month_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mon >= 8'h01) && (mon <= 8'h12));
  p_feb_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (date >= 8'h01) && (mon != 8'h02 || date <= 8'h29));
  p_bad_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_addr |-> (rd_valid && rd_data == '0));
endmodule

bind srtc_regs srtc_regs_chk #(.DATA_W(DATA_W), .HUND_TOP(HUND_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .xfer_start(xfer_start),
  .wr_valid(wr_valid), .rd_req(rd_req), .rd_valid(rd_valid),
  .bad_addr(bad_addr), .rd_data(rd_data), .ptr_set(ptr_set),
  .hund(now_t.hund), .sec(now_t.sec), .mon(now_t.mon), .date(now_t.date));

// File: tb/srtc_regs_tb_top.sv
`timescale 1ns/1ps
module srtc_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       tick_en = 0, xfer_start = 0, wr_valid = 0, rd_req = 0;
  logic [7:0] wr_data = 0;
  logic       rv0, rv1, be0, be1;
  logic [7:0] rd0, rd1;

  srtc_regs dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .xfer_start(xfer_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rv0), .rd_data(rd0), .bad_addr(be0));

  // shortened time of day: 16 ticks per day, reaches calendar rollovers
  srtc_regs #(.HUND_TOP(1), .SEC_TOP(1), .MIN_TOP(1), .HOUR_TOP(1)) cal_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .xfer_start(xfer_start),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_valid(rv1), .rd_data(rd1), .bad_addr(be1));

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [7:0] d0, d1;
    bit         e;
    int         due;
    string      tag;
  } exp_t;
  exp_t sbq[$];
  exp_t mx;

  // reference model, index 0 = dut_i, 1 = cal_i
  int hu[2], se[2], mi[2], ho[2], dw[2], dt[2], mo[2], yr[2];
  int sn[2][8];
  int ptr = 0;
  bit pset = 0;

  function automatic int tod_top(int i, int lvl);
    if (i == 1) return 1;
    case (lvl)
      0: return 99;
      1: return 59;
      2: return 59;
      default: return 23;
    endcase
  endfunction

  function automatic int mlen(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] bcd(int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int live(int i, int k);
    case (k)
      0: return hu[i];
      1: return se[i];
      2: return mi[i];
      3: return ho[i];
      4: return dw[i];
      5: return dt[i];
      6: return mo[i];
      default: return yr[i];
    endcase
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 2; i++) begin
      hu[i] = 0; se[i] = 0; mi[i] = 0; ho[i] = 0;
      dw[i] = 6; dt[i] = 1; mo[i] = 1; yr[i] = 0;  // R1 reset time
      for (int k = 1; k < 8; k++) sn[i][k] = live(i, k);
      sn[i][0] = 0;
    end
    ptr = 0; pset = 0;
  endfunction

  function automatic void model_tick();
    for (int i = 0; i < 2; i++) begin
      hu[i]++;
      if (hu[i] > tod_top(i, 0)) begin
        hu[i] = 0; se[i]++;
        if (se[i] > tod_top(i, 1)) begin
          se[i] = 0; mi[i]++;
          if (mi[i] > tod_top(i, 2)) begin
            mi[i] = 0; ho[i]++;
            if (ho[i] > tod_top(i, 3)) begin
              ho[i] = 0;
              dw[i] = (dw[i] == 6) ? 0 : dw[i] + 1;
              dt[i]++;
              if (dt[i] > mlen(mo[i], yr[i])) begin
                dt[i] = 1; mo[i]++;
                if (mo[i] > 12) begin
                  mo[i] = 1; yr[i] = (yr[i] + 1) % 100;
                end
              end
            end
          end
        end
      end
    end
  endfunction

  function automatic logic [7:0] rd_val(int i, int a);
    if (a == 0) return bcd(hu[i]);
    if (a == 1) return bcd(se[i]);
    if (a < 8) return bcd(sn[i][a]);
    return 8'h00;
  endfunction

  task automatic run_ticks(input int n);
    tick_en = 1;
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      model_tick();
    end
    tick_en = 0;
  endtask

  task automatic start_xfer();
    xfer_start = 1; pset = 0;
    @(negedge clk);
    xfer_start = 0;
  endtask

  task automatic wr_byte(input logic [7:0] d);
    wr_valid = 1; wr_data = d;
    if (pset) ptr = (ptr + 1) % 256;
    else begin ptr = d; pset = 1; end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic do_read(input string tag);
    exp_t x;
    int a;
    rd_req = 1;
    if (!pset) begin ptr = 0; pset = 1; end
    a = ptr;
    if (a == 1)
      for (int i = 0; i < 2; i++)
        for (int k = 1; k < 8; k++) sn[i][k] = live(i, k);
    x.d0 = rd_val(0, a); x.d1 = rd_val(1, a);
    x.e = (a > 19); x.due = cyc + 1; x.tag = tag;
    sbq.push_back(x);
    ptr = (ptr + 1) % 256;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic read_from(input logic [7:0] a, input int n, input string tag);
    start_xfer();
    wr_byte(a);
    for (int r = 0; r < n; r++) do_read(tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (rv0 || rv1) begin
        if (sbq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2 unexpected response actual=%h/%h expected=none", rd0, rd1);
        end else begin
          mx = sbq.pop_front();
          checks++;
          if (!(rv0 && rv1 && cyc == mx.due && rd0 == mx.d0 && rd1 == mx.d1 &&
                be0 == mx.e && be1 == mx.e)) begin
            errors++;
            $display("FAIL %s actual=%h/%h err=%b/%b cyc=%0d expected=%h/%h err=%b cyc=%0d",
                     mx.tag, rd0, rd1, be0, be1, cyc, mx.d0, mx.d1, mx.e, mx.due);
          end
        end
      end else begin
        if (be0 || be1) begin
          checks++; errors++;
          $display("FAIL R10 error pulse without response actual=%b/%b expected=0", be0, be1);
        end
        if (sbq.size() > 0 && sbq[0].due < cyc) begin
          mx = sbq.pop_front();
          checks++; errors++;
          $display("FAIL R2 missing response actual=none expected=%h at cyc %0d", mx.d0, mx.due);
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 / R3: unset pointer after reset starts at address 0
    for (int r = 0; r < 8; r++) do_read("R1");
    do_read("R3");

    // R5 / R6: live values after some ticks
    run_ticks(137);
    read_from(8'd0, 2, "R5");
    read_from(8'd1, 7, "R5");

    // R4: second byte only advances pointer, start clears it
    start_xfer();
    wr_byte(8'd5);
    wr_byte(8'hAA);
    do_read("R4");          // address 6
    start_xfer();
    do_read("R4");          // unset again: address 0
    do_read("R4");          // address 1

    // R9: snapshot held across ticks
    read_from(8'd1, 1, "R9");
    run_ticks(250);
    for (int r = 0; r < 6; r++) do_read("R9");
    read_from(8'd0, 1, "R9");

    // R10: reserved range and invalid addresses
    read_from(8'd8, 14, "R10");
    read_from(8'd19, 2, "R10");
    read_from(8'd200, 1, "R10");

    // R11: wrap from 255 to 0
    read_from(8'd255, 3, "R11");

    // R6: minute rollover on the default instance
    run_ticks(5990);
    read_from(8'd0, 1, "R6");
    read_from(8'd1, 7, "R6");
    run_ticks(300);
    read_from(8'd0, 1, "R6");
    read_from(8'd1, 7, "R6");

    // R7 / R8: one read sweep per shortened day across a leap year
    for (int d = 0; d < 1520; d++) begin
      run_ticks(16);
      read_from(8'd1, 7, (mo[1] == 2 || mo[1] == 3) ? "R8" : "R7");
    end

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 pending responses actual=%0d expected=0", sbq.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule